// File: doc/BRIEF.md
# SPI Status Flag and Request Router

This block keeps the four status flags of an SPI peripheral and turns them into service requests. The serial core reports events to it as single-cycle strobes: the transmit buffer has emptied, a byte has arrived, or a mode fault was seen. The register bus reports reads of the status register, reads of the receive data register, writes of the transmit data register and writes of the control register. Software or a DMA engine then services the peripheral through the requests that the block raises.

A single routing bit decides where the transmit-empty and receive-full flags go. When it is 0 they raise CPU interrupts. When it is 1 they raise DMA service requests. The same bit also changes how receive-full is acknowledged. A CPU must read the status register and then the data register. A DMA engine clears the flag with a bare data read. Overrun and mode fault always go to the combined receive/error CPU interrupt, whatever the routing bit.

All four request outputs are registered, so each one follows the flags and control bits it depends on by one clock. The reset is synchronous and active high.

Top module: `spi_irq_dma_ctl`

## Requirements
- R1: While reset is high, tx_empty becomes 1, rx_full, overrun and mode_fault become 0, and all four request outputs become 0.
- R2: One clock after tx_empty, cfg_tx_ie and cfg_spi_en are all 1, irq_tx is 1 if cfg_dma_sel is 0, or dma_tx is 1 if cfg_dma_sel is 1. Otherwise both are 0, and they are never 1 together.
- R3: One clock after rx_full and cfg_rx_ie are both 1, dma_rx is 1 if cfg_dma_sel is 1, or irq_rx_err is 1 if cfg_dma_sel is 0. This holds whatever the value of cfg_spi_en.
- R4: One clock after overrun or mode_fault is 1 while cfg_err_ie is 1, irq_rx_err is 1, whatever the value of cfg_dma_sel.
- R5: With cfg_dma_sel at 0, a read of the receive data register clears rx_full only if an earlier status read saw rx_full at 1. A receive data read without such a status read leaves rx_full at 1.
- R6: With cfg_dma_sel at 1, any receive data read clears rx_full.
- R7: tx_empty is set by the transmit-emptied strobe. Only a transmit data write clears it. Status reads and receive data reads leave it unchanged.
- R8: A byte arrival cancels a pending status-read acknowledgement. A receive data read that follows it leaves rx_full set when cfg_dma_sel is 0.
- R9: If a flag's set strobe and its clearing access fall in the same cycle, the flag ends that cycle at 1.
- R10: A byte arrival while rx_full is 1 sets overrun.
- R11: overrun and mode_fault clear on a control write that follows a status read that saw either of them at 1. A control write with no such read leaves them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_empty | input | 1 | Strobe: transmit buffer emptied |
| ev_rx_byte | input | 1 | Strobe: received byte placed in the data register |
| ev_mode_fault | input | 1 | Strobe: mode fault detected |
| rd_status | input | 1 | Bus read of the status register |
| rd_rxdata | input | 1 | Bus read of the receive data register |
| wr_txdata | input | 1 | Bus write of the transmit data register |
| wr_ctrl | input | 1 | Bus write of the control register |
| cfg_tx_ie | input | 1 | Transmit request enable |
| cfg_rx_ie | input | 1 | Receive request enable |
| cfg_err_ie | input | 1 | Error interrupt enable |
| cfg_spi_en | input | 1 | Peripheral enable (gates transmit requests only) |
| cfg_dma_sel | input | 1 | 1 routes transmit/receive flags to DMA requests |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| mode_fault | output | 1 | Mode-fault flag |
| irq_tx | output | 1 | Transmit CPU interrupt |
| dma_tx | output | 1 | Transmit DMA request |
| dma_rx | output | 1 | Receive DMA request |
| irq_rx_err | output | 1 | Combined receive/error CPU interrupt |

## Verification
The bench targets the acknowledge sequences. If a receive data read cleared rx_full without a prior status read, the CPU-mode check would see the flag drop early. If a byte arrival did not cancel a pending acknowledgement, a received byte would be lost without notice. The bench also drives a set strobe and a clear access in the same cycle; a design that gave the clear priority would drop the flag. It checks that cfg_spi_en gates only the transmit path and that error interrupts ignore the routing bit. A design that crossed either enable would raise or suppress the wrong request line.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int FLAG_N = 4;
  localparam int FL_TXE = 0;
  localparam int FL_RXF = 1;
  localparam int FL_OVR = 2;
  localparam int FL_MDF = 3;
  // reset values: only transmit-empty comes up set
  localparam logic [FLAG_N-1:0] FLAG_RST = 4'b0001;

  typedef struct packed {
    logic tx_ie;
    logic rx_ie;
    logic err_ie;
    logic spi_en;
    logic dma_sel;
  } cfg_t;
endpackage

// File: rtl/spi_evt_flag.sv
module spi_evt_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (set_i) q <= 1'b1;   // set has priority over clear
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/spi_flag_ctl.sv
module spi_flag_ctl
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_byte,
  input  logic              ev_mode_fault,
  input  logic              rd_status,
  input  logic              rd_rxdata,
  input  logic              wr_txdata,
  input  logic              wr_ctrl,
  input  logic              dma_sel,
  output logic [FLAG_N-1:0] flags
);
  logic [FLAG_N-1:0] set_v, clr_v;
  logic rx_arm;
  logic err_arm;

  always_comb begin
    set_v[FL_TXE] = ev_tx_empty;
    clr_v[FL_TXE] = wr_txdata;
    set_v[FL_RXF] = ev_rx_byte;
    clr_v[FL_RXF] = rd_rxdata && (dma_sel || rx_arm);
    set_v[FL_OVR] = ev_rx_byte && flags[FL_RXF];
    clr_v[FL_OVR] = wr_ctrl && err_arm;
    set_v[FL_MDF] = ev_mode_fault;
    clr_v[FL_MDF] = wr_ctrl && err_arm;
  end

  // status read that saw receive-full arms the data-read acknowledge
  always_ff @(posedge clk) begin
    if (rst)                           rx_arm <= 1'b0;
    else if (ev_rx_byte || rd_rxdata)  rx_arm <= 1'b0;
    else if (rd_status && flags[FL_RXF]) rx_arm <= 1'b1;
  end

  // status read that saw an error flag arms the control-write acknowledge
  always_ff @(posedge clk) begin
    if (rst)          err_arm <= 1'b0;
    else if (wr_ctrl) err_arm <= 1'b0;
    else if (rd_status && (flags[FL_OVR] || flags[FL_MDF])) err_arm <= 1'b1;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    spi_evt_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q     (flags[i])
    );
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flags[FL_RXF] && rd_rxdata && !dma_sel && !rx_arm && !rst) |=> flags[FL_RXF]); // R5
  AST_TX_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags[FL_TXE] && !wr_txdata) |=> flags[FL_TXE]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_rx_byte |=> flags[FL_RXF]); // R9
  AST_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_byte && flags[FL_RXF]) |=> flags[FL_OVR]); // R10
endmodule

// File: rtl/spi_req_route.sv
module spi_req_route
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_N-1:0] flags,
  input  cfg_t              cfg,
  output logic              irq_tx,
  output logic              dma_tx,
  output logic              dma_rx,
  output logic              irq_rx_err
);
  logic tx_req, rx_req, err_req;

  always_comb begin
    tx_req  = flags[FL_TXE] && cfg.tx_ie && cfg.spi_en;
    rx_req  = flags[FL_RXF] && cfg.rx_ie;
    err_req = cfg.err_ie && (flags[FL_OVR] || flags[FL_MDF]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx     <= 1'b0;
      dma_tx     <= 1'b0;
      dma_rx     <= 1'b0;
      irq_rx_err <= 1'b0;
    end else begin
      irq_tx     <= tx_req && !cfg.dma_sel;
      dma_tx     <= tx_req && cfg.dma_sel;
      dma_rx     <= rx_req && cfg.dma_sel;
      irq_rx_err <= (rx_req && !cfg.dma_sel) || err_req;
    end
  end

  AST_TX_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(irq_tx && dma_tx)); // R2
  AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_tx || dma_tx) |-> $past(flags[FL_TXE] && cfg.tx_ie && cfg.spi_en)); // R2
  AST_RX_DMA: assert property (@(posedge clk) disable iff (rst)
    dma_rx |-> $past(flags[FL_RXF] && cfg.rx_ie && cfg.dma_sel)); // R3
  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg.err_ie && (flags[FL_OVR] || flags[FL_MDF])) |-> irq_rx_err); // R4
endmodule

// File: rtl/spi_irq_dma_ctl.sv
module spi_irq_dma_ctl
  import spi_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_tx_empty,
  input  logic ev_rx_byte,
  input  logic ev_mode_fault,
  input  logic rd_status,
  input  logic rd_rxdata,
  input  logic wr_txdata,
  input  logic wr_ctrl,
  input  logic cfg_tx_ie,
  input  logic cfg_rx_ie,
  input  logic cfg_err_ie,
  input  logic cfg_spi_en,
  input  logic cfg_dma_sel,
  output logic tx_empty,
  output logic rx_full,
  output logic overrun,
  output logic mode_fault,
  output logic irq_tx,
  output logic dma_tx,
  output logic dma_rx,
  output logic irq_rx_err
);
  logic [FLAG_N-1:0] flags;
  cfg_t cfg;

  always_comb begin
    cfg.tx_ie   = cfg_tx_ie;
    cfg.rx_ie   = cfg_rx_ie;
    cfg.err_ie  = cfg_err_ie;
    cfg.spi_en  = cfg_spi_en;
    cfg.dma_sel = cfg_dma_sel;
  end

  spi_flag_ctl u_flags (
    .clk           (clk),
    .rst           (rst),
    .ev_tx_empty   (ev_tx_empty),
    .ev_rx_byte    (ev_rx_byte),
    .ev_mode_fault (ev_mode_fault),
    .rd_status     (rd_status),
    .rd_rxdata     (rd_rxdata),
    .wr_txdata     (wr_txdata),
    .wr_ctrl       (wr_ctrl),
    .dma_sel       (cfg_dma_sel),
    .flags         (flags)
  );

  spi_req_route u_route (
    .clk        (clk),
    .rst        (rst),
    .flags      (flags),
    .cfg        (cfg),
    .irq_tx     (irq_tx),
    .dma_tx     (dma_tx),
    .dma_rx     (dma_rx),
    .irq_rx_err (irq_rx_err)
  );

  assign tx_empty   = flags[FL_TXE];
  assign rx_full    = flags[FL_RXF];
  assign overrun    = flags[FL_OVR];
  assign mode_fault = flags[FL_MDF];

  AST_RST_STATE: assert property (@(posedge clk)
    $past(rst) |-> (tx_empty && !rx_full && !overrun && !mode_fault
                    && !irq_tx && !dma_tx && !dma_rx && !irq_rx_err)); // R1
endmodule

// File: tb/spi_irq_dma_ctl_test.sv
module spi_irq_dma_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_tx_empty = 0, ev_rx_byte = 0, ev_mode_fault = 0;
  logic rd_status = 0, rd_rxdata = 0, wr_txdata = 0, wr_ctrl = 0;
  logic cfg_tx_ie = 0, cfg_rx_ie = 0, cfg_err_ie = 0, cfg_spi_en = 0, cfg_dma_sel = 0;
  logic tx_empty, rx_full, overrun, mode_fault, irq_tx, dma_tx, dma_rx, irq_rx_err;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_irq_dma_ctl uut (
    .clk(clk), .rst(rst),
    .ev_tx_empty(ev_tx_empty), .ev_rx_byte(ev_rx_byte), .ev_mode_fault(ev_mode_fault),
    .rd_status(rd_status), .rd_rxdata(rd_rxdata), .wr_txdata(wr_txdata), .wr_ctrl(wr_ctrl),
    .cfg_tx_ie(cfg_tx_ie), .cfg_rx_ie(cfg_rx_ie), .cfg_err_ie(cfg_err_ie),
    .cfg_spi_en(cfg_spi_en), .cfg_dma_sel(cfg_dma_sel),
    .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun), .mode_fault(mode_fault),
    .irq_tx(irq_tx), .dma_tx(dma_tx), .dma_rx(dma_rx), .irq_rx_err(irq_rx_err)
  );

  // advance one edge; inputs change 1 ns after it, away from the edge
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {ev_tx_empty, ev_rx_byte, ev_mode_fault} = '0;
    {rd_status, rd_rxdata, wr_txdata, wr_ctrl} = '0;
    {cfg_tx_ie, cfg_rx_ie, cfg_err_ie, cfg_spi_en, cfg_dma_sel} = '0;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic byte_in();  ev_rx_byte = 1; cyc(); ev_rx_byte = 0; endtask
  task automatic st_read();  rd_status = 1;  cyc(); rd_status = 0;  endtask
  task automatic rx_read();  rd_rxdata = 1;  cyc(); rd_rxdata = 0;  endtask
  task automatic ctl_write(); wr_ctrl = 1;   cyc(); wr_ctrl = 0;    endtask

  task automatic t_reset();
    rst = 1'b1; cyc(); cyc();
    chk("R1", "tx_empty", tx_empty, 1);
    chk("R1", "rx_full", rx_full, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "mode_fault", mode_fault, 0);
    chk("R1", "requests", irq_tx | dma_tx | dma_rx | irq_rx_err, 0);
    rst = 1'b0;
  endtask

  task automatic t_tx_route();
    do_reset();
    cfg_tx_ie = 1; cfg_spi_en = 0; cyc(); cyc();
    chk("R2", "irq_tx spi off", irq_tx, 0);
    cfg_spi_en = 1; cyc(); cyc();
    chk("R2", "irq_tx cpu", irq_tx, 1);
    chk("R2", "dma_tx cpu", dma_tx, 0);
    cfg_dma_sel = 1; cyc(); cyc();
    chk("R2", "dma_tx dma", dma_tx, 1);
    chk("R2", "irq_tx dma", irq_tx, 0);
  endtask

  task automatic t_rx_route();
    do_reset();
    cfg_rx_ie = 1; cfg_spi_en = 0;
    byte_in(); cyc();
    chk("R3", "irq_rx_err cpu spi off", irq_rx_err, 1);
    cfg_dma_sel = 1; cyc(); cyc();
    chk("R3", "dma_rx", dma_rx, 1);
    chk("R3", "irq_rx_err dma", irq_rx_err, 0);
    rx_read();
    chk("R6", "rx_full after dma read", rx_full, 0);
    cyc();
    chk("R6", "dma_rx dropped", dma_rx, 0);
  endtask

  task automatic t_err_route();
    do_reset();
    cfg_err_ie = 1; cfg_dma_sel = 1;
    ev_mode_fault = 1; cyc(); ev_mode_fault = 0; cyc();
    chk("R4", "irq_rx_err on mode fault", irq_rx_err, 1);
    chk("R4", "dma_rx stays low", dma_rx, 0);
    cfg_err_ie = 0; cyc(); cyc();
    chk("R4", "irq_rx_err masked", irq_rx_err, 0);
  endtask

  task automatic t_cpu_ack();
    do_reset();
    byte_in();
    rx_read(); cyc();
    chk("R5", "rx_full after bare read", rx_full, 1);
    st_read(); rx_read();
    chk("R5", "rx_full after status+read", rx_full, 0);
  endtask

  task automatic t_tx_clear();
    do_reset();
    cfg_tx_ie = 1; cfg_spi_en = 1;
    wr_txdata = 1; cyc(); wr_txdata = 0;
    chk("R7", "tx_empty after write", tx_empty, 0);
    st_read(); rx_read(); cyc();
    chk("R7", "tx_empty after reads", tx_empty, 0);
    chk("R7", "irq_tx low", irq_tx, 0);
    ev_tx_empty = 1; cyc(); ev_tx_empty = 0;
    chk("R7", "tx_empty set by event", tx_empty, 1);
  endtask

  task automatic t_disarm();
    do_reset();
    byte_in(); st_read(); byte_in();
    chk("R10", "overrun on second byte", overrun, 1);
    rx_read(); cyc();
    chk("R8", "rx_full kept after disarm", rx_full, 1);
  endtask

  task automatic t_set_wins();
    do_reset();
    wr_txdata = 1; ev_tx_empty = 1; cyc(); wr_txdata = 0; ev_tx_empty = 0;
    chk("R9", "tx_empty set vs clear", tx_empty, 1);
    cfg_dma_sel = 1;
    rd_rxdata = 1; ev_rx_byte = 1; cyc(); rd_rxdata = 0; ev_rx_byte = 0;
    chk("R9", "rx_full set vs clear", rx_full, 1);
  endtask

  task automatic t_err_clear();
    do_reset();
    byte_in(); byte_in();
    chk("R10", "overrun set", overrun, 1);
    ctl_write(); cyc();
    chk("R11", "overrun after bare ctrl write", overrun, 1);
    st_read(); ctl_write();
    chk("R11", "overrun after status+ctrl", overrun, 0);
    chk("R11", "rx_full untouched", rx_full, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc();
    t_reset();
    t_tx_route();
    t_rx_route();
    t_err_route();
    t_cpu_ack();
    t_tx_clear();
    t_disarm();
    t_set_wins();
    t_err_clear();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule